// File: doc/BRIEF.md
# Software-Clocked Serial Shift Unit

This block is a byte-wide synchronous serial shifter for a host processor. Firmware paces every serial clock edge itself. The unit has no baud generator. As a master, each edge of the outgoing serial clock comes from a register write. Firmware either writes a new clock level or writes a one to a toggle strobe. As a slave, the unit follows an external serial clock pin. That pin and the data input pin are brought into the system clock domain through two-stage synchronizers, and their edges are detected there.

Data leaves most significant bit first on the data output pin and enters at the least significant end. Data is sampled on one edge of each serial clock cycle and the output bit changes on the other. A control bit selects which edge does which, giving SPI mode 0 or mode 1 timing. There is no select pin, so the shifter reacts to every edge it sees. A 4-bit edge counter advances on both serial clock edges. After eight full clock cycles it wraps to zero and sets a sticky done flag, which can drive an interrupt line.

Host map: address 0 is the shift register (read/write). Address 1 is status: bit 7 is the done flag and bits 3:0 are the edge counter. Address 2 is control: bit 0 master, bit 1 mode 1 timing, bit 2 clock level, bit 3 toggle strobe, bit 4 interrupt enable.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, all three registers read zero, and do_o, sck_o, sck_oe and irq_o are low.
- R2: In mode 0 (control bit 1 = 0), do_o is valid before each rising clock edge. The input is sampled on the rising edge and do_o advances on the falling edge. After eight clock cycles, the register holds the eight received bits with the first bit in bit 7, and the partner has received the old contents MSB first.
- R3: In mode 1 (control bit 1 = 1), do_o advances on each rising edge and the input is sampled on each falling edge. The eight-cycle exchange has the same result as in R2.
- R4: In master mode (control bit 0 = 1), sck_oe is high and sck_o changes only on a control write. A write with bit 3 set inverts sck_o. Any other control write sets sck_o to bit 2.
- R5: Every clock edge of the active source advances the counter by one. The sixteenth edge wraps the counter to 0 and sets the done flag (status bit 7).
- R6: The done flag stays set until a status write with bit 7 at one clears it. A status write with bit 7 at zero leaves it set.
- R7: A status write loads the counter from bits 3:0.
- R8: irq_o is high exactly when the done flag is set and control bit 4 is one.
- R9: A write to the shift register places the new bit 7 on do_o before any clock edge.
- R10: Every edge of sck_i is acted on in slave mode, since there is no select input. In master mode, sck_i edges change neither the shift register nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid one cycle after the address |
| di_i | input | 1 | Serial data input |
| sck_i | input | 1 | External serial clock (slave) |
| do_o | output | 1 | Serial data output |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| irq_o | output | 1 | Transfer done interrupt |

## Verification
The assertions assume that the external clock and data pins are held for several system clock cycles between changes. Only then does each edge survive the synchronizers as exactly one detected edge. They also assume that the master/slave and mode bits change only between transfers. The bench holds every pin level for at least four system cycles and keeps di_i stable across each sampling edge. It reconfigures the control register only while the clock is idle low. Random bytes, modes and roles come from a fixed seed.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd2;
  localparam int CB_MASTER = 0;
  localparam int CB_MODE1  = 1;
  localparam int CB_LEVEL  = 2;
  localparam int CB_TOGGLE = 3;
  localparam int CB_IRQEN  = 4;
  typedef struct packed {
    logic irq_en;
    logic mode1;
    logic master;
  } ssu_ctrl_t;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssu_edge.sv
module ssu_edge (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic rise,
  output logic fall
);
  logic src_d;
  always_ff @(posedge clk) begin
    if (rst) src_d <= 1'b0;
    else     src_d <= src;
  end
  assign rise = src & ~src_d;
  assign fall = ~src & src_d;
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         sample,
  input  logic         advance,
  input  logic         din,
  output logic [W-1:0] sr,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sr   <= load_val;
      dout <= load_val[W-1];
    end else begin
      if (sample)  sr   <= {sr[W-2:0], din};
      if (advance) dout <= sr[W-1];
    end
  end
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic wrap;
  assign wrap = step && !wr && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wr_val;
    else if (step) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              di_i,
  input  logic              sck_i,
  output logic              do_o,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(2 * DATA_W);

  ssu_ctrl_t   ctrl_q;
  logic        sck_q;
  logic        irq_q;
  logic [DATA_W-1:0] rd_q;

  logic data_wr, cnt_wr, ctrl_wr, flag_clr;
  assign data_wr  = host_wr && (host_addr == REG_DATA);
  assign cnt_wr   = host_wr && (host_addr == REG_STAT);
  assign ctrl_wr  = host_wr && (host_addr == REG_CTRL);
  assign flag_clr = cnt_wr && host_wdata[DATA_W-1];

  // pin synchronizers
  logic sck_sync, di_sync;
  ssu_sync #(.STAGES(SYNC_STGS)) u_sync_sck (.clk(clk), .rst(rst), .d(sck_i), .q(sck_sync));
  ssu_sync #(.STAGES(SYNC_STGS)) u_sync_di  (.clk(clk), .rst(rst), .d(di_i),  .q(di_sync));

  // clock source and edge detection
  logic clk_src, rise, fall, step, sample, advance;
  assign clk_src = ctrl_q.master ? sck_q : sck_sync;
  ssu_edge u_edge (.clk(clk), .rst(rst), .src(clk_src), .rise(rise), .fall(fall));
  assign step    = rise | fall;
  assign sample  = ctrl_q.mode1 ? fall : rise;
  assign advance = ctrl_q.mode1 ? rise : fall;

  // data path
  logic [DATA_W-1:0] sr;
  logic              dout;
  ssu_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(data_wr), .load_val(host_wdata),
    .sample(sample), .advance(advance), .din(di_sync), .sr(sr), .dout(dout)
  );

  // edge counter and done flag
  logic [CNT_W-1:0] cnt;
  logic             flag;
  ssu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .wr(cnt_wr), .wr_val(host_wdata[CNT_W-1:0]),
    .clr(flag_clr), .cnt(cnt), .flag(flag)
  );

  // control register and software clock
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sck_q  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q.master <= host_wdata[CB_MASTER];
      ctrl_q.mode1  <= host_wdata[CB_MODE1];
      ctrl_q.irq_en <= host_wdata[CB_IRQEN];
      if (host_wdata[CB_TOGGLE]) sck_q <= ~sck_q;
      else                       sck_q <= host_wdata[CB_LEVEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag & ctrl_q.irq_en;
  end

  // registered read port
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (host_addr)
      REG_DATA: rd_mux = sr;
      REG_STAT: begin
        rd_mux[CNT_W-1:0] = cnt;
        rd_mux[DATA_W-1]  = flag;
      end
      REG_CTRL: begin
        rd_mux[CB_MASTER] = ctrl_q.master;
        rd_mux[CB_MODE1]  = ctrl_q.mode1;
        rd_mux[CB_LEVEL]  = sck_q;
        rd_mux[CB_IRQEN]  = ctrl_q.irq_en;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign host_rdata = rd_q;
  assign do_o       = dout;
  assign sck_o      = sck_q;
  assign sck_oe     = ctrl_q.master;
  assign irq_o      = irq_q;
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag,
  input logic              flag_clr,
  input logic              irq_en,
  input logic              irq,
  input logic              ctrl_wr,
  input logic              sck_o,
  input logic              sample,
  input logic              load,
  input logic [DATA_W-1:0] sr
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    step && !cnt_wr |=> cnt == $past(cnt) + 1'b1); // R5
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    step && !cnt_wr && (cnt == {CNT_W{1'b1}}) |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag && !flag_clr |=> flag); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step && !cnt_wr |=> $stable(cnt)); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && irq_en)); // R8
  AST_SCK_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(sck_o)); // R4
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample && !load |=> $stable(sr)); // R10
endmodule

bind serial_shift_unit ssu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ssu_chk (
  .clk(clk), .rst(rst), .step(step), .cnt_wr(cnt_wr), .cnt(cnt), .flag(flag),
  .flag_clr(flag_clr), .irq_en(ctrl_q.irq_en), .irq(irq_q), .ctrl_wr(ctrl_wr),
  .sck_o(sck_q), .sample(sample), .load(data_wr), .sr(sr)
);

// File: tb/test_serial_shift_unit.sv
module test_serial_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       di_i = 1'b0;
  logic       sck_i = 1'b0;
  logic       do_o, sck_o, sck_oe, irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_unit i_serial_shift_unit (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .di_i(di_i), .sck_i(sck_i),
    .do_o(do_o), .sck_o(sck_o), .sck_oe(sck_oe), .irq_o(irq_o)
  );

  function automatic logic [7:0] ctrl_word(bit master, bit mode1, bit level, bit tog, bit irqen);
    return {3'b000, irqen, tog, level, mode1, master};
  endfunction

  function automatic logic [7:0] stat_word(bit flag, logic [3:0] cnt);
    return {flag, 3'b000, cnt};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  // slave transfer: bench is the master on sck_i / di_i
  task automatic slave_xfer(bit mode1, logic [7:0] btx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      if (!mode1) begin
        di_i = btx[i]; wait_clk(4);
        got[i] = do_o;
        sck_i = 1'b1; wait_clk(8);
        sck_i = 1'b0; wait_clk(8);
      end else begin
        sck_i = 1'b1; wait_clk(8);
        got[i] = do_o;
        di_i = btx[i]; wait_clk(4);
        sck_i = 1'b0; wait_clk(8);
      end
    end
  endtask

  // master transfer: bench is the slave, clock made by control writes
  task automatic master_xfer(bit mode1, bit irqen, logic [7:0] btx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      if (!mode1) begin
        di_i = btx[i]; wait_clk(4);
        got[i] = do_o;
        host_write(2'd2, ctrl_word(1, mode1, 0, 1, irqen)); wait_clk(8);
        host_write(2'd2, ctrl_word(1, mode1, 0, 0, irqen)); wait_clk(8);
      end else begin
        host_write(2'd2, ctrl_word(1, mode1, 0, 1, irqen)); wait_clk(8);
        got[i] = do_o;
        di_i = btx[i]; wait_clk(4);
        host_write(2'd2, ctrl_word(1, mode1, 0, 0, irqen)); wait_clk(8);
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] rd, got, dtx, btx;
    void'($urandom(32'h1234_5eed));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    host_read(2'd0, rd); check("R1 data", rd, 8'h00);
    host_read(2'd1, rd); check("R1 status", rd, 8'h00);
    host_read(2'd2, rd); check("R1 ctrl", rd, 8'h00);
    check("R1 pins", {4'b0, do_o, sck_o, sck_oe, irq_o}, 8'h00);

    // R9 data write shows bit 7
    host_write(2'd0, 8'h80); wait_clk(1);
    check("R9 do after write 80", {7'b0, do_o}, 8'h01);
    host_write(2'd0, 8'h7f); wait_clk(1);
    check("R9 do after write 7f", {7'b0, do_o}, 8'h00);

    // R2 mode 0 slave directed
    host_write(2'd2, ctrl_word(0, 0, 0, 0, 0));
    host_write(2'd1, 8'h80);
    host_write(2'd0, 8'hA5);
    slave_xfer(0, 8'h3C, got);
    check("R2 partner received", got, 8'hA5);
    host_read(2'd0, rd); check("R2 register received", rd, 8'h3C);
    host_read(2'd1, rd); check("R5 flag after 16 edges", rd, stat_word(1, 4'd0));

    // R6 write zero keeps flag, write one clears
    host_write(2'd1, 8'h00);
    host_read(2'd1, rd); check("R6 flag kept", rd, stat_word(1, 4'd0));
    host_write(2'd1, 8'h80);
    host_read(2'd1, rd); check("R6 flag cleared", rd, stat_word(0, 4'd0));

    // R3 mode 1 slave directed
    host_write(2'd2, ctrl_word(0, 1, 0, 0, 0));
    host_write(2'd0, 8'h5A);
    slave_xfer(1, 8'hC3, got);
    check("R3 partner received", got, 8'h5A);
    host_read(2'd0, rd); check("R3 register received", rd, 8'hC3);
    host_write(2'd1, 8'h80);

    // R7 counter preload, R5 wrap on sixteenth edge
    host_write(2'd2, ctrl_word(0, 0, 0, 0, 0));
    host_write(2'd1, 8'h0E);
    host_read(2'd1, rd); check("R7 counter loaded", rd, stat_word(0, 4'hE));
    sck_i = 1'b1; wait_clk(8);
    host_read(2'd1, rd); check("R5 one edge", rd, stat_word(0, 4'hF));
    sck_i = 1'b0; wait_clk(8);
    host_read(2'd1, rd); check("R5 wrap sets flag", rd, stat_word(1, 4'h0));
    host_write(2'd1, 8'h80);

    // R4 master clock control and R10 sck_i ignored in master mode
    host_write(2'd2, ctrl_word(1, 0, 1, 0, 0)); wait_clk(1);
    check("R4 level write", {6'b0, sck_o, sck_oe}, 8'h03);
    host_write(2'd2, ctrl_word(1, 0, 1, 1, 0)); wait_clk(1);
    check("R4 toggle strobe", {6'b0, sck_o, sck_oe}, 8'h01);
    host_write(2'd1, 8'h80);
    host_write(2'd0, 8'h96);
    for (int k = 0; k < 4; k++) begin
      sck_i = ~sck_i; wait_clk(8);
    end
    host_read(2'd1, rd); check("R10 counter ignores sck_i", rd, stat_word(0, 4'h0));
    host_read(2'd0, rd); check("R10 data ignores sck_i", rd, 8'h96);

    // R8 with a master mode 0 transfer
    master_xfer(0, 1, 8'hE1, got);
    check("R2 master partner received", got, 8'h96);
    host_read(2'd0, rd); check("R2 master register received", rd, 8'hE1);
    check("R8 irq set", {7'b0, irq_o}, 8'h01);
    host_write(2'd1, 8'h80); wait_clk(2);
    check("R8 irq clear", {7'b0, irq_o}, 8'h00);

    // random transfers, both roles and modes
    for (int n = 0; n < 24; n++) begin
      bit m1, mas, ie;
      m1 = 1'($urandom); mas = 1'($urandom); ie = 1'($urandom);
      dtx = 8'($urandom); btx = 8'($urandom);
      host_write(2'd2, ctrl_word(mas, m1, 0, 0, ie));
      host_write(2'd1, 8'h80);
      host_write(2'd0, dtx); wait_clk(1);
      check("R9 random do", {7'b0, do_o}, {7'b0, dtx[7]});
      if (mas) master_xfer(m1, ie, btx, got);
      else     slave_xfer(m1, btx, got);
      check(m1 ? "R3 random sent" : "R2 random sent", got, dtx);
      host_read(2'd0, rd); check(m1 ? "R3 random recv" : "R2 random recv", rd, btx);
      host_read(2'd1, rd); check("R5 random status", rd, stat_word(1, 4'h0));
      check("R8 random irq", {7'b0, irq_o}, {7'b0, ie});
    end

    done = 1'b1;
    finish_run();
  end
endmodule